// File: doc/BRIEF.md
# Long-Press Hardware Reset Timer

This block gives a device a way to force a restart that does not depend on any software still running. It watches one or two active-low push buttons. Once every enabled button has been held down together for a chosen hold time, it drives a reset request. The hold time is counted in ticks of an external 1 ms strobe. It is picked from a parameter table of at least three seconds by a select input. That select input is captured once, just after power-on reset, and is never read again.

An elaboration parameter chooses between two output styles. In level style the request stays active for as long as the buttons stay down. In pulse style the block emits a fixed-length pulse, however long the buttons are held, and it needs a full release before it can fire again. A test input removes the hold time altogether. A polarity parameter and an open-drain parameter shape the pin. In open-drain form the block only ever drives the low level and otherwise releases the pin.

Top module: `lprst_top`

## Requirements
- R1: After reset the request is inactive. In open-drain form the enable output is 0. In push-pull form the enable output is 1 and the pin sits at the inactive level.
- R2: With test input low, the request activates on the clock edge after the tick on which the hold counter reaches the selected table entry. The counter only counts while all enabled buttons read low through the synchronizer.
- R3: The two-bit select indexes the four-entry hold table (defaults 3000, 3750, 4500, 6000 ticks). With NUM_DLY = 2, only select bit 0 is used, and bit 1 has no effect on the hold time.
- R4: The select is captured on the first clock after reset is released. Later changes of the select pin do not change the hold time.
- R5: With two buttons, both must be low at the same time. A single pressed button never lets the counter advance.
- R6: Releasing any enabled button before the hold time is reached clears the count to zero, so the next press needs the full hold time again.
- R7: In level style the request stays active while the buttons stay down, including across further ticks. It goes inactive on the third clock edge after a button is released.
- R8: In pulse style the request lasts exactly PULSE_TICKS ticks, counted from activation, whether or not the buttons are released during the pulse.
- R9: In pulse style one press gives exactly one pulse. A new pulse needs all buttons released and then a fresh full hold.
- R10: With test input high, the hold time is zero. The request activates on the third clock edge after all buttons go low, with no tick needed.
- R11: With ACTIVE_HIGH = 0 and open-drain, the active request drives 0 with enable 1, and the inactive request has enable 0. With ACTIVE_HIGH = 1 and push-pull, the pin is 1 when active and 0 when inactive, and the enable is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-clock strobe every millisecond |
| btn_n | input | NUM_BTN | Reset buttons, active low, asynchronous |
| dly_sel | input | 2 | Hold-time select, captured after reset |
| test_en | input | 1 | High forces a zero hold time |
| rst_o | output | 1 | Reset request pin value |
| rst_oe | output | 1 | Pin drive enable (0 = high-Z) |

## Verification
A button edge reaches the output register through two synchronizer flops, so press and release effects are due on the third clock edge. The bench samples on falling edges after exactly two edges, where the old value must still hold, and after three, where the new value must appear. A qualifying tick changes the output on the following edge. The bench therefore issues each tick as a one-clock strobe, then lets two more edges pass before sampling. This lets it compare the output after every single tick against a tick count derived from the table entry and pulse length. Hold-time and pulse-length checks are thus exact to the tick, not windowed.

// File: rtl/lprst_pkg.sv
package lprst_pkg;

   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_ON   = 2'd1,
      PS_WAIT = 2'd2
   } pulse_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lprst_sync.sv
module lprst_sync #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   // two flops per bit; reset value is "released"
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
         end else begin
            meta_q <= d_i[i];
            sync_q <= meta_q;
         end
      end
      assign q_o[i] = sync_q;
   end
endmodule

// File: rtl/lprst_hold.sv
module lprst_hold #(
   parameter int unsigned NUM_DLY      = 4,
   parameter int unsigned DLY_TAB [4]  = '{3000, 3750, 4500, 6000},
   parameter int unsigned CNT_W        = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             all_low_i,
   input  logic             test_i,
   input  logic [1:0]       sel_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [1:0]       sel_q_o,
   output logic             cap_o,
   output logic             reached_o
);
   logic [1:0]       sel_q;
   logic             cap_q;
   logic [1:0]       idx;
   logic [CNT_W-1:0] target;
   logic [CNT_W-1:0] cnt_q;

   // one-shot capture of the select after reset release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 2'd0;
         cap_q <= 1'b0;
      end else if (!cap_q) begin
         sel_q <= sel_i;
         cap_q <= 1'b1;
      end
   end

   if (NUM_DLY == 2) begin : g_two
      assign idx = {1'b0, sel_q[0]};
   end else begin : g_four
      assign idx = sel_q;
   end

   always_comb begin
      target = CNT_W'(DLY_TAB[0]);
      case (idx)
         2'd1:    target = CNT_W'(DLY_TAB[1]);
         2'd2:    target = CNT_W'(DLY_TAB[2]);
         2'd3:    target = CNT_W'(DLY_TAB[3]);
         default: target = CNT_W'(DLY_TAB[0]);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!all_low_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q < target)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign reached_o = all_low_i && (test_i || (cnt_q >= target));
   assign cnt_o     = cnt_q;
   assign sel_q_o   = sel_q;
   assign cap_o     = cap_q;
endmodule

// File: rtl/lprst_out.sv
module lprst_out
   import lprst_pkg::*;
#(
   parameter bit          PULSE_MODE  = 1'b0,
   parameter int unsigned PULSE_TICKS = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic all_low_i,
   input  logic reached_i,
   output logic act_o
);
   localparam int unsigned PW = $clog2(PULSE_TICKS + 1);

   if (PULSE_MODE) begin : g_pulse
      pulse_state_e    st_q;
      logic [PW-1:0]   pcnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q   <= PS_IDLE;
            pcnt_q <= '0;
         end else begin
            case (st_q)
               PS_IDLE: begin
                  if (reached_i) begin
                     st_q   <= PS_ON;
                     pcnt_q <= '0;
                  end
               end
               PS_ON: begin
                  if (tick_i) begin
                     if (pcnt_q == PW'(PULSE_TICKS - 1)) st_q <= PS_WAIT;
                     else pcnt_q <= pcnt_q + 1'b1;
                  end
               end
               PS_WAIT: begin
                  if (!all_low_i) st_q <= PS_IDLE;
               end
               default: st_q <= PS_IDLE;
            endcase
         end
      end
      assign act_o = (st_q == PS_ON);
   end else begin : g_level
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= reached_i;
      end
      assign act_o = lvl_q;
   end
endmodule

// File: rtl/lprst_drv.sv
module lprst_drv #(
   parameter bit ACTIVE_HIGH = 1'b0,
   parameter bit OPEN_DRAIN  = 1'b1
) (
   input  logic act_i,
   output logic pin_o,
   output logic oe_o
);
   logic lvl;
   assign lvl = act_i ? ACTIVE_HIGH : ~ACTIVE_HIGH;

   if (OPEN_DRAIN) begin : g_od
      // only the low level is ever driven
      assign pin_o = 1'b0;
      assign oe_o  = ~lvl;
   end else begin : g_pp
      assign pin_o = lvl;
      assign oe_o  = 1'b1;
   end
endmodule

// File: rtl/lprst_top.sv
module lprst_top
   import lprst_pkg::*;
#(
   parameter int unsigned NUM_BTN     = 2,
   parameter int unsigned NUM_DLY     = 4,
   parameter int unsigned DLY_TAB [4] = '{3000, 3750, 4500, 6000},
   parameter int unsigned PULSE_TICKS = 400,
   parameter bit          PULSE_MODE  = 1'b0,
   parameter bit          ACTIVE_HIGH = 1'b0,
   parameter bit          OPEN_DRAIN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_ms,
   input  logic [NUM_BTN-1:0] btn_n,
   input  logic [1:0]         dly_sel,
   input  logic               test_en,
   output logic               rst_o,
   output logic               rst_oe
);
   localparam int unsigned MAX_DLY = max2(max2(DLY_TAB[0], DLY_TAB[1]),
                                          max2(DLY_TAB[2], DLY_TAB[3]));
   localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

   if (NUM_BTN < 1 || NUM_BTN > 2) begin : g_bad_btn
      $error("lprst_top: NUM_BTN must be 1 or 2");
   end
   if (NUM_DLY != 2 && NUM_DLY != 4) begin : g_bad_dly
      $error("lprst_top: NUM_DLY must be 2 or 4");
   end
   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("lprst_top: PULSE_TICKS must be at least 1");
   end
   if (DLY_TAB[0] < 1 || DLY_TAB[1] < 1 || DLY_TAB[2] < 1 || DLY_TAB[3] < 1) begin : g_bad_tab
      $error("lprst_top: hold table entries must be nonzero");
   end

   logic [NUM_BTN-1:0] btn_s;
   logic               all_low;
   logic [CNT_W-1:0]   hold_cnt;
   logic [1:0]         sel_q;
   logic               cap_done;
   logic               reached;
   logic               act;

   lprst_sync #(.W(NUM_BTN)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (btn_n),
      .q_o   (btn_s)
   );

   assign all_low = (btn_s == '0);

   lprst_hold #(
      .NUM_DLY (NUM_DLY),
      .DLY_TAB (DLY_TAB),
      .CNT_W   (CNT_W)
   ) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_ms),
      .all_low_i (all_low),
      .test_i    (test_en),
      .sel_i     (dly_sel),
      .cnt_o     (hold_cnt),
      .sel_q_o   (sel_q),
      .cap_o     (cap_done),
      .reached_o (reached)
   );

   lprst_out #(
      .PULSE_MODE  (PULSE_MODE),
      .PULSE_TICKS (PULSE_TICKS)
   ) out_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_ms),
      .all_low_i (all_low),
      .reached_i (reached),
      .act_o     (act)
   );

   lprst_drv #(
      .ACTIVE_HIGH (ACTIVE_HIGH),
      .OPEN_DRAIN  (OPEN_DRAIN)
   ) drv_i (
      .act_i (act),
      .pin_o (rst_o),
      .oe_o  (rst_oe)
   );
endmodule

// File: rtl/lprst_chk.sv
module lprst_chk #(
   parameter bit          PULSE_MODE = 1'b0,
   parameter int unsigned CNT_W      = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_ms,
   input logic             all_low,
   input logic             act,
   input logic [CNT_W-1:0] hold_cnt,
   input logic [1:0]       sel_q,
   input logic             cap_done
);
   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b1;
      else if (act)      armed_q <= 1'b0;
      else if (!all_low) armed_q <= 1'b1;
   end

   a_r5_rise_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> $past(all_low));

   a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !all_low |=> (hold_cnt == '0));

   a_r4_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cap_done |=> $stable(sel_q));

   a_r7_level_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
      (!PULSE_MODE && act) |-> $past(all_low));

   a_r8_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (PULSE_MODE && act && !tick_ms) |=> act);

   a_r9_rearm_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (PULSE_MODE && $rose(act)) |-> armed_q);
endmodule

bind lprst_top lprst_chk #(
   .PULSE_MODE (PULSE_MODE),
   .CNT_W      (CNT_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_ms  (tick_ms),
   .all_low  (all_low),
   .act      (act),
   .hold_cnt (hold_cnt),
   .sel_q    (sel_q),
   .cap_done (cap_done)
);

// File: tb/lprst_top_tb_top.sv
module lprst_top_tb_top;
   localparam int unsigned PT = 4;
   localparam int unsigned A_TAB [4] = '{3, 4, 5, 7};
   localparam int unsigned B_TAB [4] = '{3, 6, 9, 9};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       test_en = 1'b0;
   logic [1:0] a_btn = 2'b11;
   logic [1:0] a_sel = 2'd0;
   logic [0:0] b_btn = 1'b1;
   logic [1:0] b_sel = 2'd0;
   logic       a_o, a_oe, b_o, b_oe;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   // level style, two buttons, active-low open drain
   lprst_top #(
      .NUM_BTN(2), .NUM_DLY(4), .DLY_TAB(A_TAB), .PULSE_TICKS(PT),
      .PULSE_MODE(1'b0), .ACTIVE_HIGH(1'b0), .OPEN_DRAIN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick), .btn_n(a_btn),
      .dly_sel(a_sel), .test_en(test_en), .rst_o(a_o), .rst_oe(a_oe)
   );

   // pulse style, one button, active-high push-pull, two-entry table
   lprst_top #(
      .NUM_BTN(1), .NUM_DLY(2), .DLY_TAB(B_TAB), .PULSE_TICKS(PT),
      .PULSE_MODE(1'b1), .ACTIVE_HIGH(1'b1), .OPEN_DRAIN(1'b0)
   ) pdut_i (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick), .btn_n(b_btn),
      .dly_sel(b_sel), .test_en(test_en), .rst_o(b_o), .rst_oe(b_oe)
   );

   // 1 = active, 0 = inactive, 2 = illegal pin state
   function automatic int a_st();
      if (a_oe === 1'b1 && a_o === 1'b0) return 1;
      if (a_oe === 1'b0) return 0;
      return 2;
   endfunction

   function automatic int b_st();
      if (b_oe === 1'b1 && b_o === 1'b1) return 1;
      if (b_oe === 1'b1 && b_o === 1'b0) return 0;
      return 2;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      clks(2);
   endtask

   task automatic do_reset(input logic [1:0] sa, input logic [1:0] sb);
      @(negedge clk);
      rst_n = 1'b0;
      a_btn = 2'b11;
      b_btn = 1'b1;
      a_sel = sa;
      b_sel = sb;
      clks(3);
      rst_n = 1'b1;
      clks(3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset(2'd0, 2'd0);
      chk("R1 reset level/od", a_st(), 0);
      chk("R1 reset pulse/pp", b_st(), 0);
      chk("R11 pp oe", int'(b_oe), 1);

      // R2 R3 R7 R11: level style over every select value
      for (int s = 0; s < 4; s++) begin
         do_reset(2'(s), 2'd0);
         a_btn = 2'b00;
         clks(4);
         for (int k = 1; k <= int'(A_TAB[s]); k++) begin
            do_tick();
            chk("R2 R3 hold sweep", a_st(), (k >= int'(A_TAB[s])) ? 1 : 0);
         end
         for (int k = 0; k < 3; k++) begin
            do_tick();
            chk("R7 held across ticks", a_st(), 1);
         end
         @(negedge clk) a_btn = 2'b01;
         clks(2);
         chk("R7 release latency early", a_st(), 1);
         clks(1);
         chk("R7 release latency", a_st(), 0);
         a_btn = 2'b11;
      end

      // R3 R8 R9: pulse style over every select value (bit 1 ignored)
      for (int s = 0; s < 4; s++) begin
         int tg;
         tg = int'(B_TAB[s % 2]);
         do_reset(2'd0, 2'(s));
         b_btn = 1'b0;
         clks(4);
         for (int k = 1; k <= tg + int'(PT) + 3; k++) begin
            do_tick();
            chk("R3 R8 R9 pulse sweep", b_st(),
                (k >= tg && k < tg + int'(PT)) ? 1 : 0);
         end
         b_btn = 1'b1;
         clks(4);
      end

      // R8: release during pulse does not shorten it
      do_reset(2'd0, 2'd0);
      b_btn = 1'b0;
      clks(4);
      for (int k = 0; k < 3; k++) do_tick();
      chk("R8 pulse start", b_st(), 1);
      b_btn = 1'b1;
      clks(5);
      chk("R8 release ignored", b_st(), 1);
      for (int j = 1; j <= int'(PT); j++) begin
         do_tick();
         chk("R8 fixed width", b_st(), (j < int'(PT)) ? 1 : 0);
      end

      // R9: rearm after release gives a second pulse
      b_btn = 1'b0;
      clks(4);
      for (int k = 1; k <= 3; k++) begin
         do_tick();
         chk("R9 rearm pulse", b_st(), (k == 3) ? 1 : 0);
      end
      b_btn = 1'b1;
      for (int k = 0; k < int'(PT); k++) do_tick();

      // R5: one button alone never counts
      do_reset(2'd0, 2'd0);
      a_btn = 2'b10;
      clks(4);
      for (int k = 0; k < 10; k++) do_tick();
      chk("R5 single button", a_st(), 0);
      a_btn = 2'b00;
      clks(4);
      for (int k = 1; k <= 3; k++) begin
         do_tick();
         chk("R5 both buttons", a_st(), (k == 3) ? 1 : 0);
      end
      a_btn = 2'b11;
      clks(4);

      // R6: early release clears the count
      a_btn = 2'b00;
      clks(4);
      do_tick();
      do_tick();
      a_btn = 2'b10;
      clks(4);
      a_btn = 2'b00;
      clks(4);
      do_tick();
      do_tick();
      chk("R6 count cleared", a_st(), 0);
      do_tick();
      chk("R6 full hold", a_st(), 1);
      a_btn = 2'b11;
      clks(4);

      // R4: select change after capture is ignored
      do_reset(2'd0, 2'd0);
      a_sel = 2'd3;
      b_sel = 2'd1;
      clks(2);
      a_btn = 2'b00;
      b_btn = 1'b0;
      clks(4);
      for (int k = 1; k <= 3; k++) begin
         do_tick();
         chk("R4 latched select level", a_st(), (k == 3) ? 1 : 0);
         chk("R4 latched select pulse", b_st(), (k == 3) ? 1 : 0);
      end
      a_btn = 2'b11;
      b_btn = 1'b1;
      for (int k = 0; k < int'(PT); k++) do_tick();

      // R10: zero-delay test mode, no tick
      do_reset(2'd3, 2'd1);
      test_en = 1'b1;
      @(negedge clk) a_btn = 2'b00;
      clks(2);
      chk("R10 test latency early", a_st(), 0);
      clks(1);
      chk("R10 test zero delay", a_st(), 1);
      a_btn = 2'b11;
      clks(4);
      chk("R10 test release", a_st(), 0);
      test_en = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule